// File: doc/BRIEF.md
# Prescaled 8-bit Timer Register

This block is an up-counting 8-bit timer that sits on a microcontroller's internal register bus. It advances on instruction-cycle ticks. With the divider bypassed it moves once per tick. Otherwise a power-of-two divider sits in front of it, and its ratio comes from a 3-bit option field. Software can read the count at any time on `count_q` and can load it by writing the timer's register address. When the count passes from 0xFF to 0x00, the block raises a single-cycle overflow pulse for an interrupt controller or any other listener.

A load does two other things besides setting the count. It always empties the divider, so the first increment after the load needs a whole divide period. It also makes the timer ignore the next two ticks, so that software can read back the value it has just written before counting resumes. The block uses a synchronous, active-high reset, and both outputs are registered.

Top module: `cyc_timer8`

## Requirements
- R1: A reset clears the count, the overflow pulse, the divider and the post-write hold. After reset the first increment in divided mode comes on exactly the 2^(ratio+1)-th tick.
- R2: When `wr_en` is high and `wr_addr` equals 0x01, `wr_data` is loaded into the count, and `count_q` shows it one clock later.
- R3: A write to any other address has no effect on the count.
- R4: When `opt_bypass` is 1, every counted tick adds one to the count.
- R5: When `opt_bypass` is 0, the count adds one once every 2^(`opt_ratio`+1) counted ticks.
- R6: The count wraps from 0xFF to 0x00. On the clock that performs the wrap, `ovf_pulse` goes high for exactly one cycle. At all other times it is low.
- R7: Every load empties the divider, whatever its state, so the next increment follows a full divide period.
- R8: After a load, the next two ticks are ignored. They do not change the count and they do not advance the divider.
- R9: While no tick arrives and no load occurs, the count holds its value.
- R10: A load that arrives in the same cycle as a tick takes precedence, and the loaded value is not incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Instruction-cycle tick, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| opt_bypass | input | 1 | 1: count every tick; 0: count through the divider |
| opt_ratio | input | 3 | Divider ratio code; divide by 2^(code+1) |
| count_q | output | 8 | Current count, for register reads |
| ovf_pulse | output | 1 | One-cycle pulse on a 0xFF to 0x00 wrap |

## Verification
A load, an increment and an overflow pulse each appear on the outputs one clock after the edge that samples their cause. The bench drives inputs on the falling edge and updates its behavioural model on the rising edge, then compares on the following falling edge, so every comparison sees the result exactly one cycle after the stimulus. In divided mode an increment is due on the 2^(ratio+1)-th counted tick. After a load, counting begins only with the third tick. The directed checks count ticks to those exact positions and sample the count one tick before and one tick after each expected step.

// File: rtl/cyc_timer8_pkg.sv
package cyc_timer8_pkg;
  localparam int DEF_DATA_W     = 8;
  localparam int DEF_ADDR_W     = 8;
  localparam int DEF_RATIO_W    = 3;
  localparam int DEF_HOLD_TICKS = 2;

  // divider width needed to reach the largest ratio code
  function automatic int div_width(input int ratio_w);
    return 2 ** ratio_w;
  endfunction

  // width of a counter that holds values 0..n
  function automatic int span_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/cyc_timer8_gate.sv
module cyc_timer8_gate #(
  parameter int HOLD_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tick,
  output logic pass
);
  import cyc_timer8_pkg::*;
  localparam int HW = span_width(HOLD_TICKS);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)                       hold_q <= '0;
    else if (load)                 hold_q <= HW'(HOLD_TICKS);
    else if (tick && hold_q != '0) hold_q <= hold_q - 1'b1;
  end

  assign pass = tick && !load && (hold_q == '0);

  AST_HOLD_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> !pass); // R8
endmodule

// File: rtl/cyc_timer8_presc.sv
module cyc_timer8_presc #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               adv,
  input  logic               bypass,
  input  logic [RATIO_W-1:0] ratio,
  output logic               step
);
  import cyc_timer8_pkg::*;
  localparam int PW = div_width(RATIO_W);

  logic [PW-1:0] div_q;
  logic [PW-1:0] mask;
  logic          hit;

  always_comb begin
    for (int i = 0; i < PW; i++) mask[i] = (i <= int'(ratio));
  end

  assign hit  = ((div_q & mask) == mask);
  assign step = adv && (bypass || hit);

  always_ff @(posedge clk) begin
    if (rst || clr)          div_q <= '0;
    else if (adv && !bypass) div_q <= hit ? '0 : div_q + 1'b1;
  end

  AST_DIV_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> (div_q == '0)); // R7
  AST_BYPASS_NO_DIV: assert property (@(posedge clk) disable iff (rst)
    (bypass && !clr) |=> $stable(div_q)); // R4
endmodule

// File: rtl/cyc_timer8_count.sv
module cyc_timer8_count #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              step,
  output logic [DATA_W-1:0] count_q,
  output logic              ovf_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else if (load) begin
      count_q <= load_val;
      ovf_q   <= 1'b0;
    end else begin
      ovf_q <= step && (&count_q);
      if (step) count_q <= count_q + 1'b1;
    end
  end

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    load |=> (count_q == $past(load_val))); // R2
  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> (count_q == '0)); // R6
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> !ovf_q); // R6
endmodule

// File: rtl/cyc_timer8.sv
module cyc_timer8 #(
  parameter int              DATA_W     = 8,
  parameter int              ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] TMR_ADDR = 8'h01,
  parameter int              RATIO_W    = 3,
  parameter int              HOLD_TICKS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               opt_bypass,
  input  logic [RATIO_W-1:0] opt_ratio,
  output logic [DATA_W-1:0]  count_q,
  output logic               ovf_pulse
);
  logic wr_hit;
  logic tick_pass;
  logic step;

  assign wr_hit = wr_en && (wr_addr == TMR_ADDR);

  cyc_timer8_gate #(.HOLD_TICKS(HOLD_TICKS)) u_gate (
    .clk(clk), .rst(rst), .load(wr_hit), .tick(tick), .pass(tick_pass)
  );

  cyc_timer8_presc #(.RATIO_W(RATIO_W)) u_presc (
    .clk(clk), .rst(rst), .clr(wr_hit), .adv(tick_pass),
    .bypass(opt_bypass), .ratio(opt_ratio), .step(step)
  );

  cyc_timer8_count #(.DATA_W(DATA_W)) u_count (
    .clk(clk), .rst(rst), .load(wr_hit), .load_val(wr_data),
    .step(step), .count_q(count_q), .ovf_q(ovf_pulse)
  );

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_hit) |=> $stable(count_q)); // R9
  AST_FOREIGN_ADDR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_hit && !tick) |=> $stable(count_q)); // R3
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && tick) |=> (count_q == $past(wr_data))); // R10
  AST_OVF_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !ovf_pulse); // R6
endmodule

// File: tb/cyc_timer8_bench.sv
module cyc_timer8_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       tick;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic       opt_bypass;
  logic [2:0] opt_ratio;
  logic [7:0] count_q;
  logic       ovf_pulse;

  always #2.5 clk = ~clk;

  cyc_timer8 u_cyc_timer8 (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .opt_bypass(opt_bypass), .opt_ratio(opt_ratio),
    .count_q(count_q), .ovf_pulse(ovf_pulse)
  );

  int    checks = 0;
  int    bad = 0;
  int    cycles = 0;
  string req = "R1";

  // behavioural reference model
  int m_cnt = 0, m_div = 0, m_hold = 0;
  bit m_ovf = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_cnt = 0; m_div = 0; m_hold = 0; m_ovf = 0;
    end else if (wr_en && wr_addr == 8'h01) begin
      m_cnt = wr_data; m_div = 0; m_hold = 2; m_ovf = 0;
    end else begin
      bit inc;
      inc = 0;
      m_ovf = 0;
      if (tick) begin
        if (m_hold > 0) m_hold--;
        else if (opt_bypass) inc = 1;
        else begin
          m_div++;
          if (m_div >= (1 << (opt_ratio + 1))) begin m_div = 0; inc = 1; end
        end
      end
      if (inc) begin
        if (m_cnt == 255) begin m_cnt = 0; m_ovf = 1; end
        else m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (count_q !== 8'(m_cnt) || ovf_pulse !== m_ovf) begin
        bad++;
        $display("FAIL %s model: count=%0h ovf=%0b expected count=%0h ovf=%0b",
                 req, count_q, ovf_pulse, m_cnt, m_ovf);
      end
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic cyc(input int n, input bit tk);
    for (int i = 0; i < n; i++) begin
      tick = tk;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #20000;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    opt_bypass = 1'b1; opt_ratio = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 count", count_q, 0);
    chk("R1 ovf", ovf_pulse, 0);

    req = "R2"; wr(8'h01, 8'h10);
    chk("R2", count_q, 8'h10);
    req = "R8"; cyc(2, 1);
    chk("R8", count_q, 8'h10);
    req = "R4"; cyc(1, 1);
    chk("R4", count_q, 8'h11);
    cyc(4, 1);
    chk("R4", count_q, 8'h15);

    req = "R3"; wr(8'h02, 8'h77);
    chk("R3", count_q, 8'h15);
    req = "R9"; cyc(10, 0);
    chk("R9", count_q, 8'h15);

    req = "R6"; wr(8'h01, 8'hFD); cyc(2, 1); cyc(2, 1);
    chk("R6 before wrap", count_q, 8'hFF);
    chk("R6 no early ovf", ovf_pulse, 0);
    cyc(1, 1);
    chk("R6 wrap", count_q, 8'h00);
    chk("R6 ovf", ovf_pulse, 1);
    cyc(1, 0);
    chk("R6 ovf single", ovf_pulse, 0);

    req = "R5"; opt_bypass = 1'b0; opt_ratio = 3'd1;
    wr(8'h01, 8'h00); cyc(2, 1); cyc(3, 1);
    chk("R5 div4 early", count_q, 0);
    cyc(1, 1);
    chk("R5 div4", count_q, 1);
    cyc(4, 1);
    chk("R5 div4 again", count_q, 2);
    opt_ratio = 3'd0; wr(8'h01, 8'h20); cyc(2, 1); cyc(1, 1);
    chk("R5 div2 early", count_q, 8'h20);
    cyc(1, 1);
    chk("R5 div2", count_q, 8'h21);
    opt_ratio = 3'd3; wr(8'h01, 8'h00); cyc(2, 1); cyc(15, 1);
    chk("R5 div16 early", count_q, 0);
    cyc(1, 1);
    chk("R5 div16", count_q, 1);

    req = "R7"; opt_ratio = 3'd2; wr(8'h01, 8'h00); cyc(2, 1); cyc(5, 1);
    wr(8'h01, 8'h40); cyc(2, 1); cyc(7, 1);
    chk("R7 full period", count_q, 8'h40);
    cyc(1, 1);
    chk("R7 step", count_q, 8'h41);

    req = "R6"; opt_ratio = 3'd0; wr(8'h01, 8'hFF); cyc(2, 1); cyc(1, 1);
    chk("R6 div2 hold", count_q, 8'hFF);
    cyc(1, 1);
    chk("R6 div2 wrap", count_q, 0);
    chk("R6 div2 ovf", ovf_pulse, 1);

    req = "R10"; tick = 1'b1; wr(8'h01, 8'h99); tick = 1'b0;
    chk("R10", count_q, 8'h99);

    req = "R1"; opt_ratio = 3'd1; wr(8'h01, 8'h00); cyc(2, 1); cyc(2, 1);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R1 reset count", count_q, 0);
    cyc(3, 1);
    chk("R1 divider cleared", count_q, 0);
    cyc(1, 1);
    chk("R1 first step", count_q, 1);

    cyc(4, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule